// File: doc/BRIEF.md
# Half-Duplex Serial Frame Transmitter with Contention Detection

This block sends one byte at a time over a single shared, bidirectional data wire that is held high by a pull-up inside the pad. Every internal register runs on the clock supplied by the external programmer. The access layer presents a byte and pulses a load strobe. The block then builds a twelve-slot frame and shifts it out. The frame is a low start slot, the eight data bits with the least significant first, an even-parity slot, and two high stop slots. Line values change on the falling edge so that the far end can sample them on the rising edge.

The pad is a push-pull tri-state driver, and this block controls its data value and its enable. A zero is always driven actively. In a run of ones only the first slot is driven high. The driver then lets go and the pull-up keeps the wire high until the next zero. On every rising edge of a frame, the block compares the sensed wire level with the bit it intends to send in that slot. A mismatch means the programmer is fighting for the wire. The block then cuts the driver enable at that same edge, drops the frame, raises a sticky collision flag and falls back to receive mode with the driver off.

Top module: `hdtx_serializer`

## Requirements
- R1: After reset, busy, done and collision are low and the driver enable is low.
- R2: The wire level (the driven value when enabled, high otherwise) carries, slot by slot: a 0 start slot, data bit 0 up to data bit 7, the XOR of the eight data bits, then 1 and 1. Slot k occupies the k-th falling edge after the rising edge that accepted the load (k counted from 0).
- R3: The driven value and the enable hold steady from one falling edge to just before the next rising edge. Outputs change only on falling edges, apart from the enable withdrawal of R8 and R10.
- R4: The driver enable is high in every slot whose bit is 0.
- R5: In a slot whose bit is 1, the enable is high only when the previous slot's bit was 0 (the start slot counts as 0). Otherwise the driver is released.
- R6: A load strobe is accepted only while idle, and busy rises at the rising edge that takes it. A strobe during a frame changes nothing on the wire.
- R7: After a frame with no mismatch, done is high for exactly one cycle, from the rising edge that samples the second stop slot. Busy falls at that same edge.
- R8: When the sensed level differs from the intended bit at a rising edge during a frame, busy and the driver enable fall at that edge, the collision flag rises, and done does not pulse.
- R9: The collision flag stays high until the clear input is sampled high. A new mismatch in the same cycle wins over the clear.
- R10: When a frame ends, by completion or by collision, the driver enable stays low until the next accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programmer clock; sampling on rising edge, line updates on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Request to send `data_i` (honoured only when idle) |
| data_i | input | DATA_W | Byte to transmit |
| coll_clr_i | input | 1 | Clears the sticky collision flag |
| line_i | input | 1 | Sensed level of the shared data wire |
| drv_o | output | 1 | Value presented to the pad driver |
| oe_o | output | 1 | Pad driver enable (high = drive) |
| busy_o | output | 1 | A frame is in flight |
| done_o | output | 1 | One-cycle pulse on clean frame completion |
| coll_o | output | 1 | Sticky contention flag |

## Verification
The hardest case to reach is a collision inside a released stretch of ones. There the block is not driving at all, and only an external pull-down exposes the fight. The bench models the wire as a resolution of the block's driver, the pull-up and a programmer-side forcing driver. It sends a byte whose upper nibble gives a run of ones, then pulls the wire low in the second slot of that run. It checks that the frame dies at that rising edge and that nothing is driven afterwards. A second case forces the wire high while the block is driving a zero. A third loads a new byte mid-frame to show the running frame is untouched.

// File: rtl/hdtx_pkg.sv
package hdtx_pkg;

    typedef enum logic {
        TXM_RECV = 1'b0,
        TXM_SEND = 1'b1
    } txm_e;

    typedef struct packed {
        logic drv;
        logic oe;
    } pad_ctl_t;

endpackage

// File: rtl/hdtx_frame_pack.sv
module hdtx_frame_pack #(
    parameter int DATA_W = 8,
    parameter int STOP_W = 2,
    localparam int FRAME_W = DATA_W + STOP_W + 2
) (
    input  logic [DATA_W-1:0]  data_i,
    output logic [FRAME_W-1:0] frame_o
);
    // Slot 0 is sent first: start(0), data LSB first, even parity, stops(1).
    always_comb begin
        frame_o                   = '0;
        frame_o[0]                = 1'b0;
        frame_o[DATA_W:1]         = data_i;
        frame_o[DATA_W+1]         = ^data_i;
        frame_o[FRAME_W-1:DATA_W+2] = {STOP_W{1'b1}};
    end
endmodule

// File: rtl/hdtx_pad_drive.sv
module hdtx_pad_drive
    import hdtx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    input  logic cur_bit_i,
    input  logic prev_bit_i,
    output logic drv_o,
    output logic oe_o
);
    pad_ctl_t pad_d, pad_q;

    // Zeros always driven; a one is driven only if it follows a zero.
    always_comb begin
        pad_d.drv = busy_i ? cur_bit_i : 1'b1;
        pad_d.oe  = busy_i & (~cur_bit_i | ~prev_bit_i);
    end

    // Falling-edge update so the far end samples on the rising edge.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pad_q.drv <= 1'b1;
            pad_q.oe  <= 1'b0;
        end else begin
            pad_q <= pad_d;
        end
    end

    assign drv_o = pad_q.drv;
    assign oe_o  = pad_q.oe;
endmodule

// File: rtl/hdtx_serializer.sv
module hdtx_serializer
    import hdtx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STOP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              coll_clr_i,
    input  logic              line_i,
    output logic              drv_o,
    output logic              oe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              coll_o
);
    localparam int FRAME_W = DATA_W + STOP_W + 2;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        txm_e               mode;
        logic [FRAME_W-1:0] sh;
        logic               prev;
        logic [CNT_W-1:0]   cnt;
        logic               done;
        logic               coll;
    } seq_t;

    seq_t st_d, st_q;
    logic [FRAME_W-1:0] frame_w;
    logic               oe_raw;
    logic               busy_w;
    logic               mismatch_w;

    hdtx_frame_pack #(
        .DATA_W (DATA_W),
        .STOP_W (STOP_W)
    ) u_pack (
        .data_i  (data_i),
        .frame_o (frame_w)
    );

    assign busy_w     = (st_q.mode == TXM_SEND);
    assign mismatch_w = busy_w && (line_i != st_q.sh[0]);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (coll_clr_i) begin
            st_d.coll = 1'b0;
        end
        case (st_q.mode)
            TXM_RECV: begin
                if (load_i) begin
                    st_d.mode = TXM_SEND;
                    st_d.sh   = frame_w;
                    st_d.prev = 1'b0;
                    st_d.cnt  = '0;
                end
            end
            default: begin
                if (mismatch_w) begin
                    st_d.mode = TXM_RECV;
                    st_d.coll = 1'b1;
                end else begin
                    st_d.prev = st_q.sh[0];
                    st_d.sh   = {1'b1, st_q.sh[FRAME_W-1:1]};
                    st_d.cnt  = st_q.cnt + 1'b1;
                    if (st_q.cnt == LAST_SLOT) begin
                        st_d.mode = TXM_RECV;
                        st_d.done = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode <= TXM_RECV;
            st_q.sh   <= '1;
            st_q.prev <= 1'b1;
            st_q.cnt  <= '0;
            st_q.done <= 1'b0;
            st_q.coll <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    hdtx_pad_drive u_pad (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_w),
        .cur_bit_i  (st_q.sh[0]),
        .prev_bit_i (st_q.prev),
        .drv_o      (drv_o),
        .oe_o       (oe_raw)
    );

    // Enable withdrawn at the very rising edge that ends the frame.
    assign oe_o   = oe_raw & busy_w;
    assign busy_o = busy_w;
    assign done_o = st_q.done;
    assign coll_o = st_q.coll;

    a_r4_zero_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && !st_q.sh[0]) |-> oe_o);

    a_r5_run_released: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && st_q.sh[0] && st_q.prev) |-> !oe_o);

    a_r6_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_w && load_i) |=> busy_o);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r8_coll_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_w |=> (!busy_o && !oe_o && coll_o && !done_o));

    a_r9_coll_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_o && !coll_clr_i) |=> coll_o);
endmodule

// File: tb/tb_hdtx_serializer.sv
module tb_hdtx_serializer;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 8;
    localparam int FW     = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load = 1'b0;
    logic [DATA_W-1:0] data = '0;
    logic coll_clr = 1'b0;
    logic force_en = 1'b0;
    logic force_val = 1'b1;
    logic line;
    logic drv, oe, busy, done, coll;
    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    // Wire resolution: programmer force > block driver > pull-up.
    assign line = force_en ? force_val : (oe ? drv : 1'b1);

    hdtx_serializer dut (
        .clk(clk), .rst_n(rst_n), .load_i(load), .data_i(data),
        .coll_clr_i(coll_clr), .line_i(line), .drv_o(drv), .oe_o(oe),
        .busy_o(busy), .done_o(done), .coll_o(coll)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [FW-1:0] exp_frame(input logic [DATA_W-1:0] b);
        return {2'b11, ^b, b, 1'b0};
    endfunction

    // Sends byte b; optional mid-frame load of alt at slot inj;
    // optional forcing of the wire to fval at slot cslot (collision).
    task automatic send(input logic [DATA_W-1:0] b, input int inj,
                        input logic [DATA_W-1:0] alt, input int cslot, input logic fval);
        logic [FW-1:0] f;
        logic eoe, lvl, s_drv, s_oe;
        f = exp_frame(b);
        @(negedge clk); #1;
        load = 1'b1; data = b;
        @(posedge clk); #1;
        load = 1'b0;
        chk(busy == 1'b1, "R6 busy after load", busy, 1);
        for (int k = 0; k < FW; k++) begin
            @(negedge clk); #1;
            load = 1'b0;
            eoe = (k == 0) || !f[k] || !f[k-1];
            lvl = oe ? drv : 1'b1;
            chk(lvl == f[k], $sformatf("R2 slot %0d level", k), lvl, f[k]);
            if (!f[k]) chk(oe == 1'b1, $sformatf("R4 slot %0d zero driven", k), oe, 1);
            else chk(oe == eoe, $sformatf("R5 slot %0d one enable", k), oe, eoe);
            s_drv = drv; s_oe = oe;
            if (k == cslot) begin
                force_en = 1'b1; force_val = fval;
                @(posedge clk); #1;
                chk(busy == 1'b0, "R8 busy dropped", busy, 0);
                chk(oe == 1'b0, "R8 enable dropped", oe, 0);
                chk(coll == 1'b1, "R8 collision flag", coll, 1);
                chk(done == 1'b0, "R8 no done", done, 0);
                force_en = 1'b0;
                for (int j = 0; j < 14; j++) begin
                    @(negedge clk); #2;
                    chk(oe == 1'b0, "R10 quiet after collision", oe, 0);
                    chk(done == 1'b0, "R8 no done later", done, 0);
                end
                return;
            end
            #(CLK_P/2 - 3);
            chk(drv == s_drv && oe == s_oe, $sformatf("R3 slot %0d stable", k),
                {drv, oe}, {s_drv, s_oe});
            if (k == inj) begin
                load = 1'b1; data = alt;
            end
        end
        @(posedge clk); #1;
        chk(busy == 1'b0, "R7 busy low at end", busy, 0);
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(oe == 1'b0, "R10 enable off at end", oe, 0);
        @(posedge clk); #1;
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        @(negedge clk); #2;
        chk(oe == 1'b0, "R10 enable stays off", oe, 0);
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(oe == 1'b0, "R1 enable", oe, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(coll == 1'b0, "R1 collision", coll, 0);
    endtask

    task automatic t_patterns();
        send(8'h00, -1, 8'h00, -1, 1'b0);
        send(8'hFF, -1, 8'h00, -1, 1'b0);
        send(8'hA5, -1, 8'h00, -1, 1'b0);
        send(8'h01, -1, 8'h00, -1, 1'b0);
        send(8'h80, -1, 8'h00, -1, 1'b0);
        send(8'h7E, -1, 8'h00, -1, 1'b0);
    endtask

    task automatic t_load_while_busy();
        // R6: second strobe at slot 4 must not disturb the 0x3C frame
        send(8'h3C, 4, 8'hC3, -1, 1'b0);
        chk(busy == 1'b0, "R6 ignored strobe did not restart", busy, 0);
    endtask

    task automatic t_coll_released();
        // 0xF0: slot 6 is a released one; pull the wire low there
        send(8'hF0, -1, 8'h00, 6, 1'b0);
        chk(coll == 1'b1, "R9 flag holds", coll, 1);
        @(negedge clk); coll_clr = 1'b1;
        @(posedge clk); #1; coll_clr = 1'b0;
        chk(coll == 1'b0, "R9 flag cleared", coll, 0);
    endtask

    task automatic t_coll_driven_zero();
        // 0x00: slot 2 is a driven zero; programmer forces high
        send(8'h00, -1, 8'h00, 2, 1'b1);
        chk(coll == 1'b1, "R9 flag holds after zero clash", coll, 1);
        send(8'h5A, -1, 8'h00, -1, 1'b0);
        chk(coll == 1'b1, "R9 flag survives clean frame", coll, 1);
        @(negedge clk); coll_clr = 1'b1;
        @(posedge clk); #1; coll_clr = 1'b0;
        chk(coll == 1'b0, "R9 flag cleared again", coll, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1; t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #1; t_reset();
        t_patterns();
        t_load_while_busy();
        t_coll_released();
        t_coll_driven_zero();
        repeat (3) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule